// File: doc/BRIEF.md
# Serial Shift Slice with Word Swap

This block is one serial I/O lane. A 32-bit working word moves one place toward bit 0 on every shift strobe, taking its new top bit from a synchronized serial input pin; bit 0 of the working word drives the serial output pin. The strobes come from a 12-bit down counter. It counts the system clock while the slice runs and reloads from a programmable value, so one strobe occurs every (reload + 1) clocks. Software can preset the counter before starting the slice, which sets the phase of the first strobe.

An 8-bit position counter counts strobes to mark word boundaries. On the strobe where it stands at zero, the working word and a 32-bit spare word trade places in a single cycle, the position counter reloads, and a one-cycle word mark is raised. Software fills and drains the spare word while the working word is being shifted.

A simple register port gives read and write access to every piece of state and to a run bit. Reads return registered data one cycle after the address is presented.

Top module: `shift_slice`

## Requirements
- R1: After a synchronous reset, every register reads zero (working word, spare word, reload, counter, position, position reload, run bit), and the serial output and word mark are low.
- R2: On each strobe that is not a boundary, the working word shifts right by one and bit 31 takes the serial input value. That value has passed two synchronizer flops, so the bit driven before edge k enters the word at edge k+2.
- R3: The serial output always equals bit 0 of the working word.
- R4: While running, the down counter decrements every clock. When it is at zero it produces a strobe in that cycle and loads the reload value. With the counter started at 0, strobes occur at running edges 1, r+2, 2r+3, and so on.
- R5: A value written to the counter while the slice is stopped delays the first strobe to running edge (value + 1).
- R6: The position counter decrements on each strobe. On a strobe where it is zero it loads the position reload value, and the word mark is high for exactly the following cycle.
- R7: On a boundary strobe, the working word takes the spare word's old value, and the spare word takes the working word shifted right with the synchronized input in bit 31.
- R8: A bus write to a register wins over a hardware update of that register in the same cycle.
- R9: While the run bit is clear, the counter, position and working word hold their values, and no strobe, swap or word mark occurs.
- R10: The register map is: 0 working word, 1 spare word, 2 reload (12 bits), 3 counter (12 bits), 4 position (8 bits), 5 position reload (8 bits), 6 run bit (bit 0), 7 reads zero. Unused upper bits read zero, and read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register index for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ser_in | input | 1 | Serial input pin |
| ser_out | output | 1 | Serial output pin |
| word_mark | output | 1 | One-cycle word boundary flag |

## Verification
The assertions check on every cycle the step of the down counter, the step of the position counter on a strobe, the one-place shift of the working word, the source of the working word after a swap, the freeze while the slice is stopped, and the zero upper bits of narrow reads. The bench's scenarios cover what needs a count over many cycles: the strobe rate and phase for several reload and preset values, the two-cycle latency of the serial input, the exact contents of both words after a swap, and bus writes that land in the same cycle as hardware updates.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [2:0] {
    RA_WORK   = 3'd0,
    RA_SPARE  = 3'd1,
    RA_RELOAD = 3'd2,
    RA_COUNT  = 3'd3,
    RA_POS    = 3'd4,
    RA_POSRLD = 3'd5,
    RA_RUN    = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/slice_sync.sv
module slice_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= 1'b0;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 1'b0;
          else     pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/slice_rate_gen.sv
module slice_rate_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] reload,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             strobe
);
  assign strobe = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_val;
    else if (strobe) cnt_q <= reload;
    else if (run)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/slice_pos_ctr.sv
module slice_pos_ctr #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             wr_pos,
  input  logic             wr_rld,
  input  logic [POS_W-1:0] wr_val,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] rld_q,
  output logic             wrap,
  output logic             mark
);
  assign wrap = strobe && (pos_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         pos_q <= '0;
    else if (wr_pos) pos_q <= wr_val;
    else if (wrap)   pos_q <= rld_q;
    else if (strobe) pos_q <= pos_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         rld_q <= '0;
    else if (wr_rld) rld_q <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (rst) mark <= 1'b0;
    else     mark <= wrap;
  end
endmodule

// File: rtl/slice_shift_reg.sv
module slice_shift_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              wrap,
  input  logic              sin,
  input  logic              wr_work,
  input  logic              wr_spare,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] work_q,
  output logic [DATA_W-1:0] spare_q
);
  logic [DATA_W-1:0] shifted;
  assign shifted = {sin, work_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)          work_q <= '0;
    else if (wr_work) work_q <= wr_val;
    else if (wrap)    work_q <= spare_q;
    else if (strobe)  work_q <= shifted;
  end

  always_ff @(posedge clk) begin
    if (rst)           spare_q <= '0;
    else if (wr_spare) spare_q <= wr_val;
    else if (wrap)     spare_q <= shifted;
  end
endmodule

// File: rtl/shift_slice.sv
module shift_slice #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 12,
  parameter int POS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              word_mark
);
  import slice_pkg::*;

  localparam int CNT_PAD = DATA_W - CNT_W;
  localparam int POS_PAD = DATA_W - POS_W;

  logic              run_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  posrld_q;
  logic [DATA_W-1:0] work_q;
  logic [DATA_W-1:0] spare_q;
  logic              strobe;
  logic              wrap;
  logic              sin_s;

  logic wr_work, wr_spare, wr_reload, wr_count, wr_pos, wr_posrld, wr_run;
  assign wr_work   = bus_wr && (bus_addr == RA_WORK);
  assign wr_spare  = bus_wr && (bus_addr == RA_SPARE);
  assign wr_reload = bus_wr && (bus_addr == RA_RELOAD);
  assign wr_count  = bus_wr && (bus_addr == RA_COUNT);
  assign wr_pos    = bus_wr && (bus_addr == RA_POS);
  assign wr_posrld = bus_wr && (bus_addr == RA_POSRLD);
  assign wr_run    = bus_wr && (bus_addr == RA_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_run)    run_q    <= bus_wdata[0];
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  slice_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ser_in), .q(sin_s)
  );

  slice_rate_gen #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst(rst), .run(run_q), .reload(reload_q),
    .wr_cnt(wr_count), .wr_val(bus_wdata[CNT_W-1:0]),
    .cnt_q(cnt_q), .strobe(strobe)
  );

  slice_pos_ctr #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .strobe(strobe),
    .wr_pos(wr_pos), .wr_rld(wr_posrld), .wr_val(bus_wdata[POS_W-1:0]),
    .pos_q(pos_q), .rld_q(posrld_q), .wrap(wrap), .mark(word_mark)
  );

  slice_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .strobe(strobe), .wrap(wrap), .sin(sin_s),
    .wr_work(wr_work), .wr_spare(wr_spare), .wr_val(bus_wdata),
    .work_q(work_q), .spare_q(spare_q)
  );

  assign ser_out = work_q[0];

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        RA_WORK:   bus_rdata <= work_q;
        RA_SPARE:  bus_rdata <= spare_q;
        RA_RELOAD: bus_rdata <= {{CNT_PAD{1'b0}}, reload_q};
        RA_COUNT:  bus_rdata <= {{CNT_PAD{1'b0}}, cnt_q};
        RA_POS:    bus_rdata <= {{POS_PAD{1'b0}}, pos_q};
        RA_POSRLD: bus_rdata <= {{POS_PAD{1'b0}}, posrld_q};
        RA_RUN:    bus_rdata <= {{(DATA_W-1){1'b0}}, run_q};
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/shift_slice_chk.sv
module shift_slice_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int POS_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [POS_W-1:0]  pos_q,
  input logic [DATA_W-1:0] work_q,
  input logic [DATA_W-1:0] spare_q,
  input logic              word_mark
);
  logic stb;
  assign stb = run_q && (cnt_q == '0);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q != '0 && !(bus_wr && bus_addr == 3'd3)) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && pos_q != '0 && !(bus_wr && bus_addr == 3'd4)) |=> pos_q == $past(pos_q) - 1'b1);

  // R6
  mark_cause_chk: assert property (@(posedge clk) disable iff (rst)
    word_mark |-> ($past(run_q) && $past(cnt_q) == '0 && $past(pos_q) == '0));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && pos_q != '0 && !(bus_wr && bus_addr == 3'd0)) |=> work_q[DATA_W-2:0] == $past(work_q[DATA_W-1:1]));

  // R7
  swap_src_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && pos_q == '0 && !(bus_wr && bus_addr == 3'd0)) |=> work_q == $past(spare_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !bus_wr) |=> ($stable(cnt_q) && $stable(pos_q) && $stable(work_q) && !word_mark));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 3'd3) |=> bus_rdata[DATA_W-1:CNT_W] == '0);
endmodule

bind shift_slice shift_slice_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .run_q(run_q), .cnt_q(cnt_q), .pos_q(pos_q), .work_q(work_q), .spare_q(spare_q),
  .word_mark(word_mark)
);

// File: tb/tb_shift_slice.sv
module tb_shift_slice;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        ser_in = 1'b0;
  logic        ser_out;
  logic        word_mark;

  int checks = 0;
  int errors = 0;

  shift_slice dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_in(ser_in),
    .ser_out(ser_out), .word_mark(word_mark)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; commits at the next posedge, returns at the negedge after
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic setup(input int rl, input int c0, input int p, input int prl, input logic [31:0] w);
    wr(3'd6, 32'd0);
    wr(3'd2, rl);
    wr(3'd3, c0);
    wr(3'd5, prl);
    wr(3'd4, p);
    wr(3'd0, w);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    check("R1 ser_out", {31'd0, ser_out}, 32'd0);
    check("R1 word_mark", {31'd0, word_mark}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check($sformatf("R1 reg %0d", a), v, 32'd0);
    end

    // R10: reserved bits read zero
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R10 reload", v, 32'h0000_0FFF);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check("R10 count", v, 32'h0000_0FFF);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); check("R10 pos", v, 32'h0000_00FF);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); check("R10 posrld", v, 32'h0000_00FF);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); check("R10 run", v, 32'h0000_0001);
    wr(3'd6, 32'd0);
    wr(3'd1, 32'h1357_9BDF); rd(3'd1, v); check("R10 spare", v, 32'h1357_9BDF);
    rd(3'd7, v); check("R10 hole", v, 32'd0);

    // R9: stopped slice holds
    setup(0, 5, 9, 9, 32'hDEAD_BEEF);
    ser_in = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (word_mark) check("R9 mark while stopped", 32'd1, 32'd0);
    end
    rd(3'd3, v); check("R9 count held", v, 32'd5);
    rd(3'd4, v); check("R9 pos held", v, 32'd9);
    rd(3'd0, v); check("R9 work held", v, 32'hDEAD_BEEF);

    // R4 / R5 / R2 / R3 / R6: rate and phase sweep, serial input held at 1
    for (int rl = 0; rl < 6; rl++) begin
      for (int ci = 0; ci < 3; ci++) begin
        for (int ni = 0; ni < 3; ni++) begin
          int c0, n, c, s;
          logic [31:0] ew;
          c0 = (ci == 0) ? 0 : (ci == 1) ? 2 : 5;
          n  = (ni == 0) ? 1 : (ni == 1) ? 7 : 20;
          setup(rl, c0, 255, 255, 32'd0);
          c = c0; s = 0; ew = 32'd0;
          for (int i = 0; i < n; i++) begin
            if (c == 0) begin s++; c = rl; ew = {1'b1, ew[31:1]}; end
            else c--;
          end
          wr(3'd6, 32'd1);
          repeat (n - 1) @(negedge clk);
          wr(3'd6, 32'd0);
          check($sformatf("R3 ser_out r=%0d c=%0d n=%0d", rl, c0, n), {31'd0, ser_out}, {31'd0, ew[0]});
          rd(3'd3, v);
          check($sformatf("%s count r=%0d c=%0d n=%0d", (c0 == 0) ? "R4" : "R5", rl, c0, n), v, c);
          rd(3'd0, v);
          check($sformatf("R2 work r=%0d c=%0d n=%0d", rl, c0, n), v, ew);
          rd(3'd4, v);
          check($sformatf("R6 pos r=%0d c=%0d n=%0d", rl, c0, n), v, 255 - s);
        end
      end
    end

    // R2: synchronizer latency with a bit pattern
    begin
      logic [15:0] pat;
      logic s1, s2;
      logic [31:0] ew;
      pat = 16'hB38E;
      ser_in = 1'b0;
      setup(0, 0, 255, 255, 32'd0);
      s1 = 1'b0; s2 = 1'b0; ew = 32'd0;
      wr(3'd6, 32'd1);
      for (int k = 0; k < 16; k++) begin
        ser_in = pat[k];
        @(posedge clk);
        ew = {s2, ew[31:1]}; s2 = s1; s1 = pat[k];
        @(negedge clk);
      end
      ser_in = 1'b0;
      wr(3'd6, 32'd0);
      ew = {s2, ew[31:1]};
      rd(3'd0, v); check("R2 sync pattern", v, ew);
    end

    // R7 / R6: boundary swap
    ser_in = 1'b1;
    setup(0, 0, 3, 3, 32'd0);
    wr(3'd1, 32'hA5A5_0F0F);
    wr(3'd6, 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check($sformatf("R6 no mark edge %0d", i + 2), {31'd0, word_mark}, 32'd0);
    end
    check("R6 no mark edge 1", {31'd0, word_mark}, 32'd0);
    wr(3'd6, 32'd0);
    check("R6 mark after boundary", {31'd0, word_mark}, 32'd1);
    check("R3 ser_out after swap", {31'd0, ser_out}, 32'd1);
    @(negedge clk);
    check("R6 mark one cycle", {31'd0, word_mark}, 32'd0);
    rd(3'd0, v); check("R7 work after swap", v, 32'hA5A5_0F0F);
    rd(3'd1, v); check("R7 spare after swap", v, 32'hF000_0000);
    rd(3'd4, v); check("R6 pos reloaded", v, 32'd3);

    // R8: bus writes win over hardware updates
    ser_in = 1'b0;
    setup(0, 0, 200, 200, 32'd0);
    repeat (3) @(negedge clk);
    wr(3'd6, 32'd1);
    wr(3'd0, 32'h1234_5678);
    wr(3'd3, 32'd7);
    wr(3'd6, 32'd0);
    rd(3'd0, v); check("R8 work write wins", v, 32'h091A_2B3C);
    rd(3'd3, v); check("R8 count write wins", v, 32'd6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule